// File: doc/BRIEF.md
# SD Card Clock Generator with Glitch-Free Gating

This block derives the clock for an SD or eMMC card from the host clock. A 17-bit control word picks the division ratio, turns the card clock on or off, and can stop it on its own while no command or data transfer is in progress. The ratio is always a power of two from 2 to 512, or to 1024 when that option is built in. A separate bypass code passes the host clock through unchanged.

Along with the card clock, the block drives a one-cycle enable strobe in the host clock domain. The command and data shifters use it to step once per card clock rising edge, so they never need to clock from the divided signal. Start, stop and ratio changes follow the card clock's phase, so the output never carries a shortened high pulse. Software clears the enable bit, rewrites the ratio and sets the enable bit again. A ratio written while the clock runs is held back until the clock has stopped.

Top module: `sdclk_gen`

## Requirements
- R1: After reset `sd_clk` and `sd_clk_en` are low.
- R2: With bits 7:0, 10 and 16 of `clk_ctrl` all zero and the enable bit (bit 8) set, `sd_clk` has a period of 2 host cycles and is high for 1 of them.
- R3: When bit i (0..7) is the only set bit among 7:0, 10 and 16, the period is 2^(i+2) host cycles and `sd_clk` is high for exactly half of each period.
- R4: When several of bits 7:0 are set, the lowest set bit alone sets the ratio, and bit 16 is then ignored.
- R5: With `HAS_DIV1024`=1, bit 16 alone among the ratio bits gives a period of 1024. With `HAS_DIV1024`=0, bit 16 has no effect, so bit 16 alone gives a period of 2 and bit 7 gives the slowest period of 512.
- R6: Bit 10 selects bypass and takes precedence over every other ratio bit. While running in bypass, `sd_clk` equals `clk` and `sd_clk_en` is high every cycle.
- R7: While the enable bit (bit 8) is clear, `sd_clk` stays low and `sd_clk_en` stays low. The only exception is the completion of a high phase already under way (R9).
- R8: With the auto-off bit (bit 9) set, the clock runs only while `xfer_busy` is high. With bit 9 clear, `xfer_busy` has no effect.
- R9: The clock stops only in its low phase. A high phase under way when the clock is told to stop runs to its full length.
- R10: The ratio and the bypass choice are captured only while the clock is stopped. A change written while it runs has no effect until the next stop.
- R11: In divided mode `sd_clk_en` is high for exactly one host cycle per card clock period: the first host cycle of each high phase.
- R12: On start, the first low phase is a full half period: the first strobe comes on the (N/2+1)-th host clock edge after the enable is applied, where N is the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_ctrl | input | CTRL_W | Control word: bits 7:0 one-hot ratio, 8 enable, 9 auto-off, 10 bypass, 16 divide by 1024 |
| xfer_busy | input | 1 | High while a command or data transfer is active |
| sd_clk | output | 1 | Card clock |
| sd_clk_en | output | 1 | One host-cycle strobe per card clock rising edge |

## Verification
The hardest case to reach is a stop request that lands in the middle of a high phase. A stop at any other time is trivially clean. To reach it, the bench runs the divide-by-16 setting, waits for the strobe that opens a high phase, and clears the enable bit in that same cycle. It then counts the high samples that follow. The deferred ratio change is reached the same way: the new ratio is written just after a strobe while the clock runs, and the bench measures the next whole period at the old rate.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // Control word bit positions; software depends on these.
  localparam int unsigned FLD_ONEHOT_LSB = 0;
  localparam int unsigned BIT_RUN_EN    = 8;
  localparam int unsigned BIT_AUTO_OFF  = 9;
  localparam int unsigned BIT_BYPASS    = 10;
  localparam int unsigned BIT_LONG_DIV  = 16;
  localparam int unsigned CTRL_MIN_W    = 17;

  // Selected rate: bypass or divide by 2**log2div.
  typedef struct packed {
    logic       bypass;
    logic [3:0] log2div;
  } rate_sel_t;

  // Decode the ratio bits; the lowest one-hot bit wins, bypass beats all.
  function automatic rate_sel_t decode_rate(input logic [CTRL_MIN_W-1:0] word,
                                            input logic has_long);
    rate_sel_t s;
    s.bypass  = word[BIT_BYPASS];
    s.log2div = 4'd1;
    if (!s.bypass) begin
      if (word[FLD_ONEHOT_LSB +: 8] != 8'd0) begin
        for (int i = 7; i >= 0; i--)
          if (word[FLD_ONEHOT_LSB + i]) s.log2div = 4'(i + 2);
      end else if (has_long && word[BIT_LONG_DIV]) begin
        s.log2div = 4'd10;
      end
    end
    return s;
  endfunction

  // Half period in host cycles for a ratio of 2**k.
  function automatic logic [15:0] half_period(input logic [3:0] k);
    return 16'(16'd1 << (k - 4'd1));
  endfunction

  // Mask of the counter bits that span one period of 2**k.
  function automatic logic [15:0] period_mask(input logic [3:0] k);
    return 16'((17'd1 << k) - 17'd1);
  endfunction

endpackage

// File: rtl/sdclk_decode.sv
module sdclk_decode
  import sdclk_pkg::*;
#(
  parameter int unsigned CTRL_W      = 32,
  parameter bit          HAS_DIV1024 = 1'b1
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              busy,
  output rate_sel_t         sel,
  output logic              want_run
);
  logic [CTRL_MIN_W-1:0] word;
  assign word = ctrl[CTRL_MIN_W-1:0];

  always_comb begin
    sel      = decode_rate(word, HAS_DIV1024);
    // Auto-off lets the clock run only while a transfer is active.
    want_run = word[BIT_RUN_EN] && (!word[BIT_AUTO_OFF] || busy);
  end
endmodule

// File: rtl/sdclk_phase.sv
module sdclk_phase
  import sdclk_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      want_run,
  input  rate_sel_t sel_new,
  output logic      run,
  output rate_sel_t sel_act,
  output logic      div_lvl,
  output logic      rise_stb,
  output logic      load_evt,
  output logic      stop_evt
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_mask;
  logic [CNT_W-1:0] cnt_half;

  always_comb begin
    cnt_mask = CNT_W'(period_mask(sel_act.log2div));
    cnt_half = CNT_W'(half_period(sel_act.log2div));
    div_lvl  = !sel_act.bypass && ((cnt & cnt_half) != '0);
    rise_stb = run && (sel_act.bypass || ((cnt & cnt_mask) == cnt_half));
    load_evt = !run;
    // Stopping is allowed only while the divided level is low.
    stop_evt = run && !want_run && !div_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      cnt     <= '0;
      sel_act <= '{bypass: 1'b0, log2div: 4'd1};
    end else if (load_evt) begin
      cnt     <= '0;
      sel_act <= sel_new;
      run     <= want_run;
    end else begin
      cnt <= cnt + 1'b1;
      if (stop_evt) run <= 1'b0;
    end
  end
endmodule

// File: rtl/sdclk_bypass_gate.sv
module sdclk_bypass_gate (
  input  logic clk,
  input  logic enable,
  output logic gclk
);
  logic en_lat;

  // Enable is sampled while the host clock is low.
  always_latch begin
    if (!clk) en_lat = enable;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int unsigned CTRL_W      = 32,
  parameter bit          HAS_DIV1024 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] clk_ctrl,
  input  logic              xfer_busy,
  output logic              sd_clk,
  output logic              sd_clk_en
);
  localparam int unsigned CNT_W = HAS_DIV1024 ? 10 : 9;

  rate_sel_t sel_new;
  rate_sel_t sel_act;
  logic      want_run;
  logic      run;
  logic      div_lvl;
  logic      div_out;
  logic      byp_clk;
  logic      load_evt;
  logic      stop_evt;

  sdclk_decode #(.CTRL_W(CTRL_W), .HAS_DIV1024(HAS_DIV1024)) u_dec (
    .ctrl     (clk_ctrl),
    .busy     (xfer_busy),
    .sel      (sel_new),
    .want_run (want_run)
  );

  sdclk_phase #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .want_run (want_run),
    .sel_new  (sel_new),
    .run      (run),
    .sel_act  (sel_act),
    .div_lvl  (div_lvl),
    .rise_stb (sd_clk_en),
    .load_evt (load_evt),
    .stop_evt (stop_evt)
  );

  sdclk_bypass_gate u_gate (
    .clk    (clk),
    .enable (run && sel_act.bypass),
    .gclk   (byp_clk)
  );

  assign div_out = run && div_lvl;
  assign sd_clk  = sel_act.bypass ? byp_clk : div_out;
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       div_lvl,
  input logic       div_out,
  input logic       ce,
  input logic       byp_act,
  input logic [3:0] log2div,
  input logic       load_evt
);
  logic [10:0] hi_len;
  logic [15:0] half_c;

  assign half_c = 16'(16'd1 << (log2div - 4'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= '0;
    else        hi_len <= div_out ? hi_len + 1'b1 : '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !ce && !div_out); // R1
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $fell(div_out) |-> 16'(hi_len) == half_c); // R3
  AST_BYPASS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (run && byp_act) |-> ce); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !ce && !div_out); // R7
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(run) |-> !$past(div_lvl)); // R9
  AST_HOLD_RATE: assert property (@(posedge clk) disable iff (!rst_n) !$past(load_evt) |-> $stable(log2div) && $stable(byp_act)); // R10
  AST_STROBE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) (ce && !byp_act) |-> div_out && !$past(div_out)); // R11
endmodule

bind sdclk_gen sdclk_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .div_lvl  (div_lvl),
  .div_out  (div_out),
  .ce       (sd_clk_en),
  .byp_act  (sel_act.bypass),
  .log2div  (sel_act.log2div),
  .load_evt (load_evt)
);

// File: tb/sim_sdclk_gen.sv
module sim_sdclk_gen;
  localparam int CLK_P = 10;
  localparam logic [31:0] EN   = 32'h100;
  localparam logic [31:0] AUTO = 32'h200;
  localparam logic [31:0] BYP  = 32'h400;
  localparam logic [31:0] LONG = 32'h10000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl = '0;
  logic        busy = 1'b0;
  logic        sd0, ce0, sd1, ce1;
  int          n_chk = 0;
  int          n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  sdclk_gen #(.CTRL_W(32), .HAS_DIV1024(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_ctrl(ctrl), .xfer_busy(busy),
    .sd_clk(sd0), .sd_clk_en(ce0));

  sdclk_gen #(.CTRL_W(32), .HAS_DIV1024(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .clk_ctrl(ctrl), .xfer_busy(busy),
    .sd_clk(sd1), .sd_clk_en(ce1));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic smp(input bit sel, output logic s, output logic c);
    @(posedge clk);
    #1;
    s = sel ? sd1 : sd0;
    c = sel ? ce1 : ce0;
  endtask

  // Starts the clock, checks the start latency, one full period and the stop.
  task automatic run_div(input bit sel, input logic [31:0] bits, input int exp, input string req);
    logic s, c;
    int first = 0, per = 0, hi = 1;
    ctrl = bits | EN;
    for (int n = 1; n <= 2100; n++) begin
      smp(sel, s, c);
      if (c) begin first = n; break; end
    end
    check(first == exp/2 + 1, "R12", first, exp/2 + 1);
    for (int n = 1; n <= 2100; n++) begin
      smp(sel, s, c);
      per++;
      if (c) break;
      if (s) hi++;
    end
    check(per == exp, req, per, exp);
    check(hi == exp/2, req, hi, exp/2);
    ctrl = bits;
    repeat (exp + 4) smp(sel, s, c);
    check(!s && !c, "R7", int'(s), 0);
  endtask

  task automatic t_reset;
    #1;
    check(!sd0 && !ce0, "R1", int'(sd0), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_rates;
    run_div(0, 32'h0, 2, "R2");
    for (int i = 0; i < 8; i++) run_div(0, 32'h1 << i, 4 << i, "R3");
    run_div(0, 32'h0C, 16, "R4");
    run_div(0, 32'h8 | LONG, 32, "R4");
    run_div(0, LONG, 1024, "R5");
    run_div(1, LONG, 2, "R5");
    run_div(1, 32'h80, 512, "R5");
  endtask

  task automatic t_enable_off;
    logic s, c;
    int hits = 0;
    ctrl = 32'h1;
    repeat (20) begin smp(0, s, c); if (s || c) hits++; end
    check(hits == 0, "R7", hits, 0);
  endtask

  task automatic t_auto_off;
    logic s, c;
    int hits = 0;
    busy = 1'b0;
    ctrl = EN | AUTO | 32'h1;
    repeat (20) begin smp(0, s, c); if (s || c) hits++; end
    check(hits == 0, "R8", hits, 0);
    busy = 1'b1;
    run_div(0, AUTO | 32'h1, 4, "R8");
    ctrl = EN | 32'h1;
    busy = 1'b0;
    hits = 0;
    repeat (20) begin smp(0, s, c); if (c) hits++; end
    check(hits == 5, "R8", hits, 5);
    ctrl = 32'h0;
    repeat (8) smp(0, s, c);
  endtask

  task automatic t_stop_phase;
    logic s, c;
    int hi = 1, lows = 0;
    ctrl = EN | 32'h4;
    for (int n = 0; n < 40; n++) begin smp(0, s, c); if (c) break; end
    ctrl = 32'h4;
    for (int n = 0; n < 40; n++) begin smp(0, s, c); if (!s) break; hi++; end
    check(hi == 8, "R9", hi, 8);
    repeat (20) begin smp(0, s, c); if (s) lows++; end
    check(lows == 0, "R9", lows, 0);
  endtask

  task automatic t_deferred;
    logic s, c;
    int per = 0;
    ctrl = EN | 32'h1;
    for (int n = 0; n < 20; n++) begin smp(0, s, c); if (c) break; end
    ctrl = EN | 32'h2;
    for (int n = 0; n < 20; n++) begin smp(0, s, c); per++; if (c) break; end
    check(per == 4, "R10", per, 4);
    ctrl = 32'h2;
    repeat (12) smp(0, s, c);
    run_div(0, 32'h2, 8, "R10");
  endtask

  task automatic t_bypass;
    int bad = 0;
    ctrl = EN | BYP | 32'h1;
    repeat (4) @(posedge clk);
    repeat (6) begin
      @(posedge clk); #2;
      if (!sd0 || !ce0) bad++;
      @(negedge clk); #2;
      if (sd0) bad++;
    end
    check(bad == 0, "R6", bad, 0);
    ctrl = BYP;
    repeat (3) @(posedge clk);
    bad = 0;
    repeat (4) begin
      @(posedge clk); #2;
      if (sd0 || ce0) bad++;
    end
    check(bad == 0, "R7", bad, 0);
    ctrl = 32'h0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 3 + 2);
    t_reset;
    t_rates;
    t_enable_off;
    t_auto_off;
    t_stop_phase;
    t_deferred;
    t_bypass;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule